// File: doc/BRIEF.md
# Self-Timed Fall-Through FIFO Stage Chain

This block is a clocked first-in first-out buffer, 64 words deep and 4 bits wide by default. Each storage stage has its own occupancy bit. A word written at the input end advances one stage per clock toward the output while the next stage is empty. When a word leaves at the output, the vacancy it leaves behind travels back toward the input at the same rate of one stage per clock.

Each side has a ready flag and a strobe. The input side offers `inReady`, which drops for a cycle after each accepted word and then rises again by itself. The output side offers `outReady`, which is high whenever a word sits in the last stage, with that word already on `dataOut`. Two instances chain with no glue logic: the upstream `outReady` drives the downstream `shiftIn`, the upstream `dataOut` drives the downstream `dataIn`, and the downstream `inReady` drives the upstream `shiftOut`. The pair then acts as one buffer of twice the depth. A synchronous `clear` empties every stage.

Top module: `fallthru_fifo`

## Requirements
- R1: One instance holds exactly DEPTH words, and two chained instances hold exactly 2*DEPTH words. Once full, `inReady` stays low until a word leaves.
- R2: Words leave in the order they were accepted, with none lost, duplicated or altered, whether `shiftOut` is held high or pulsed.
- R3: A word accepted at a clock edge into an empty instance raises `outReady` DEPTH-1 edges later. In a chain of two empty instances, the downstream `outReady` rises 2*DEPTH-1 edges after the upstream accept edge.
- R4: A word is accepted at an edge where `shiftIn` and `inReady` are both high. `inReady` is then low for the following cycle. If stage two is empty, `inReady` is high again one cycle after that. `shiftIn` while `inReady` is low has no effect.
- R5: A word is removed at an edge where `shiftOut` and `outReady` are both high, and `outReady` is low in the next cycle. With `shiftOut` held high, each word therefore produces a single-cycle `outReady` pulse. In a chain, the upstream instance shows exactly one such pulse per word.
- R6: Start from a full instance and remove one word. The vacancy reaches the input after DEPTH-1 further edges. In a full chain of two, removing one word downstream produces a one-cycle downstream `inReady` pulse that moves exactly one word across. The upstream `inReady` then rises 2*DEPTH-1 edges after the removal edge.
- R7: While `outReady` is high, `dataOut` carries the oldest stored word. It holds steady until that word is removed.
- R8: `shiftOut` while `outReady` is low has no effect.
- R9: An edge with `clear` high empties every stage, so afterwards `inReady` is high and `outReady` is low. Words held before the clear never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clear | input | 1 | Synchronous clear, active high |
| shiftIn | input | 1 | Write strobe, honoured while `inReady` is high |
| dataIn | input | WIDTH | Word to write |
| inReady | output | 1 | Input stage is empty |
| shiftOut | input | 1 | Remove strobe, honoured while `outReady` is high |
| dataOut | output | WIDTH | Word in the last stage |
| outReady | output | 1 | Last stage holds a word |

## Verification
The hardest state to reach from the ports is the one where a single vacancy crawls back through two completely full instances. Only then do the one-cycle downstream `inReady` pulse and the 2*DEPTH-1 bubble latency show up. The bench reaches this state by holding the upstream write strobe high with the downstream output blocked until the chain refuses further words. It then issues one single-cycle removal and counts edges until the far input reports ready. In that same window it counts how many cycles the internal handshake pulse stays high.

// File: rtl/fallthru_fifo_pkg.sv
package fallthru_fifo_pkg;

  // Handshake flags presented by the control path
  typedef struct packed {
    logic inReady;
    logic outReady;
  } ftFlags_t;

  // Next occupancy of one stage; clear dominates, a fill and a drain never coincide
  function automatic logic ftNextOcc(input logic cur, input logic fill,
                                     input logic drain, input logic clr);
    logic nxt;
    if (clr)        nxt = 1'b0;
    else if (fill)  nxt = 1'b1;
    else if (drain) nxt = 1'b0;
    else            nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/fallthru_fifo_ctrl.sv
module fallthru_fifo_ctrl
  import fallthru_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             shiftIn,
  input  logic             shiftOut,
  output logic [DEPTH-1:0] stageLoad,
  output ftFlags_t         flags
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] occ;
  logic [DEPTH-1:0] drain;
  logic             acceptIn;
  logic             releaseOut;

  assign acceptIn   = shiftIn  & ~occ[0];
  assign releaseOut = shiftOut &  occ[LAST];

  for (genvar i = 0; i < DEPTH; i++) begin : gStage
    // A stage fills from its upstream neighbour (or the input) when it is empty
    if (i == 0) begin : gHead
      assign stageLoad[i] = acceptIn;
    end else begin : gBody
      assign stageLoad[i] = occ[i-1] & ~occ[i];
    end

    // A stage drains into its downstream neighbour (or the output)
    if (i == LAST) begin : gTail
      assign drain[i] = releaseOut;
    end else begin : gPass
      assign drain[i] = occ[i] & ~occ[i+1];
    end

    always_ff @(posedge clk) begin
      occ[i] <= ftNextOcc(occ[i], stageLoad[i], drain[i], clear);
    end
  end

  assign flags.inReady  = ~occ[0];
  assign flags.outReady =  occ[LAST];

endmodule

// File: rtl/fallthru_fifo_data.sv
module fallthru_fifo_data #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic [DEPTH-1:0] stageLoad,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] stageData [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : gReg
    if (i == 0) begin : gHead
      always_ff @(posedge clk) begin
        if (stageLoad[i]) stageData[i] <= dataIn;
      end
    end else begin : gBody
      always_ff @(posedge clk) begin
        if (stageLoad[i]) stageData[i] <= stageData[i-1];
      end
    end
  end

  assign dataOut = stageData[LAST];

endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo
  import fallthru_fifo_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic [WIDTH-1:0] dataOut,
  output logic             outReady
);

  logic [DEPTH-1:0] stageLoad;
  ftFlags_t         flags;

  fallthru_fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .clear     (clear),
    .shiftIn   (shiftIn),
    .shiftOut  (shiftOut),
    .stageLoad (stageLoad),
    .flags     (flags)
  );

  fallthru_fifo_data #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .stageLoad (stageLoad),
    .dataIn    (dataIn),
    .dataOut   (dataOut)
  );

  assign inReady  = flags.inReady;
  assign outReady = flags.outReady;

endmodule

// File: rtl/fallthru_fifo_chk.sv
module fallthru_fifo_chk #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input logic             clk,
  input logic             clear,
  input logic             shiftIn,
  input logic             inReady,
  input logic             shiftOut,
  input logic [WIDTH-1:0] dataOut,
  input logic             outReady
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] fill;
  logic          up;
  logic          down;

  assign up   = shiftIn  & inReady;
  assign down = shiftOut & outReady;

  always_ff @(posedge clk) begin
    if (clear) fill <= '0;
    else       fill <= fill + CW'(up) - CW'(down);
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (clear)
    fill <= CW'(DEPTH));

  // R1
  full_blocks_input_chk: assert property (@(posedge clk) disable iff (clear)
    (fill == CW'(DEPTH)) |-> !inReady);

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (clear)
    (shiftIn && inReady) |=> !inReady);

  // R5
  release_gap_chk: assert property (@(posedge clk) disable iff (clear)
    (shiftOut && outReady) |=> !outReady);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (clear)
    (outReady && !shiftOut) |=> (outReady && $stable(dataOut)));

  // R8
  empty_no_output_chk: assert property (@(posedge clk) disable iff (clear)
    (fill == '0) |-> (!outReady && inReady));

  // R9
  clear_state_chk: assert property (@(posedge clk) disable iff (clear)
    $fell(clear) |-> (inReady && !outReady));

endmodule

bind fallthru_fifo fallthru_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uChk (
  .clk      (clk),
  .clear    (clear),
  .shiftIn  (shiftIn),
  .inReady  (inReady),
  .shiftOut (shiftOut),
  .dataOut  (dataOut),
  .outReady (outReady)
);

// File: tb/tb_fallthru_fifo.sv
`timescale 1ns/1ps
module tb_fallthru_fifo;

  localparam int WIDTH = 4;
  localparam int DEPTH = 64;
  localparam int CAP   = 2 * DEPTH;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             clear;
  logic             siA;
  logic [WIDTH-1:0] dinA;
  logic             dirA;
  logic             dirB;
  logic             dorA;
  logic             dorB;
  logic             soB;
  logic [WIDTH-1:0] qA;
  logic [WIDTH-1:0] qB;

  fallthru_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
    .clk(clk), .clear(clear), .shiftIn(siA), .dataIn(dinA), .inReady(dirA),
    .shiftOut(dirB), .dataOut(qA), .outReady(dorA));

  fallthru_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dutTail (
    .clk(clk), .clear(clear), .shiftIn(dorA), .dataIn(qA), .inReady(dirB),
    .shiftOut(soB), .dataOut(qB), .outReady(dorB));

  int compared   = 0;
  int mismatched = 0;
  int pushes     = 0;
  int pops       = 0;
  logic [WIDTH-1:0] model [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: compared every cycle, then advanced by the coming edge
  always begin
    @(negedge clk);
    #5;
    if (!clear && dorB) begin
      compared++;
      if (model.size() == 0) begin
        mismatched++;
        $display("FAIL R2 actual=%0d expected=none (output ready with empty model)", qB);
      end else if (qB !== model[0]) begin
        mismatched++;
        $display("FAIL R7 actual=%0d expected=%0d", qB, model[0]);
      end
    end
    if (clear) begin
      model.delete();
    end else begin
      if (soB && dorB && model.size() > 0) begin
        void'(model.pop_front());
        pops++;
      end
      if (siA && dirA) begin
        model.push_back(dinA);
        pushes++;
      end
    end
  end

  initial begin
    #(200000 * 20);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int cnt;
    int hi;
    int p0;
    clear = 1'b1; siA = 1'b0; soB = 1'b0; dinA = '0;
    repeat (3) @(negedge clk);
    clear = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(dirA && dirB, "R9 inReady after clear", int'(dirA && dirB), 1);
    check(!dorA && !dorB, "R9 outReady after clear", int'(dorA || dorB), 0);

    // R8: removal strobes on an empty chain
    soB = 1'b1;
    repeat (3) @(negedge clk);
    soB = 1'b0;
    check(!dorB && model.size() == 0, "R8 no output from empty", int'(dorB), 0);

    // R3/R4/R5: one word through two empty instances
    dinA = 4'h9; siA = 1'b1;
    @(negedge clk);
    siA = 1'b0;
    check(!dirA, "R4 input busy after accept", int'(dirA), 0);
    cnt = 1; hi = 0;
    forever begin
      if (dorA) hi++;
      if (cnt == 2) check(dirA, "R4 input ready again", int'(dirA), 1);
      if (dorB || cnt > 1000) break;
      @(negedge clk);
      cnt++;
    end
    check(cnt == CAP, "R3 cascade ripple latency", cnt, CAP);
    check(hi == 1, "R5 single upstream pulse", hi, 1);
    check(qB == 4'h9, "R7 word on output", qB, 9);
    soB = 1'b1;
    @(negedge clk);
    soB = 1'b0;
    check(!dorB, "R5 output ready drops after removal", int'(dorB), 0);

    // R1/R4: fill the chain with the write strobe held high
    p0 = pushes;
    siA = 1'b1;
    for (int c = 0; c < 1200; c++) begin
      dinA = WIDTH'(c * 7 + 3);
      @(negedge clk);
    end
    check(pushes - p0 == CAP, "R1 chain capacity", pushes - p0, CAP);
    check(!dirA && dorB, "R1 full flags", int'(dirA), 0);
    repeat (50) @(negedge clk);
    check(model.size() == CAP, "R4 strobe ignored when full", model.size(), CAP);
    siA = 1'b0;
    @(negedge clk);

    // R6: one removal from the full chain, vacancy bubbles back
    soB = 1'b1;
    @(negedge clk);
    soB = 1'b0;
    cnt = 1; hi = 0;
    forever begin
      if (dirB) hi++;
      if (dirA || cnt > 1000) break;
      @(negedge clk);
      cnt++;
    end
    check(cnt == CAP, "R6 cascade bubble latency", cnt, CAP);
    check(hi == 1, "R6 downstream ready pulse width", hi, 1);
    check(model.size() == CAP - 1, "R6 one word moved", model.size(), CAP - 1);

    // R2/R5: drain with removal held high
    p0 = pops;
    soB = 1'b1;
    repeat (1500) @(negedge clk);
    soB = 1'b0;
    check(pops - p0 == CAP - 1, "R5 drained count", pops - p0, CAP - 1);
    check(model.size() == 0 && !dorB && dirA, "R2 empty after drain", model.size(), 0);

    // R2/R8: pulsed write then pulsed removal
    p0 = pushes;
    for (int c = 0; c < 90; c++) begin
      siA = (c % 3 == 0);
      dinA = WIDTH'(c * 5 + 1);
      @(negedge clk);
    end
    siA = 1'b0;
    for (int c = 0; c < 1500; c++) begin
      soB = (c % 4 == 0);
      @(negedge clk);
    end
    soB = 1'b0;
    check(pushes - p0 > 20, "R2 pulsed words accepted", pushes - p0, 21);
    check(model.size() == 0 && !dorB, "R2 pulsed drain complete", model.size(), 0);

    // R9: clear with words in flight
    siA = 1'b1; dinA = 4'h3;
    repeat (12) @(negedge clk);
    siA = 1'b0;
    repeat (30) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check(dirA && dirB && !dorA && !dorB, "R9 flags after clear", int'(dorA || dorB), 0);
    dinA = 4'hA; siA = 1'b1;
    @(negedge clk);
    siA = 1'b0;
    repeat (CAP + 5) @(negedge clk);
    check(dorB && qB == 4'hA && model.size() == 1, "R9 only new word remains", qB, 10);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule